// File: doc/BRIEF.md
# Hardware Cursor Overlay

A 32 by 32 pixel cursor is laid over a stream of 24-bit pixels. Software loads two planes of 32 row words each, a transparency mask and a colour-select plane, and a packed position word through a 32-bit register bus with byte offsets. A free miscellaneous register is also kept. The raster side supplies the current column and line, the active display width and height, the underlying pixel and the two overlay colours, which come from a palette outside the block.

For every pixel the block decides whether the raster coordinate falls inside the cursor square and inside the visible area. It selects the mask and colour bits for that row and column. It then registers either the incoming pixel or one of the two overlay colours. Register reads are combinational from the offset; only the miscellaneous register reads back.

Top module: `cursor_overlay`

## Requirements
- R1: A write to offset 0x8FC sets the cursor column X from data bits 31:16 and the cursor line Y from bits 15:0.
- R2: A read at offset 0x818 returns the last value written there ORed with 0x02000000; after reset that value is zero.
- R3: Reads at every other offset, including the position and both planes, return zero.
- R4: Mask row r is written at offset 0x900+4r and colour row r at 0x980+4r, for r from 0 to 31. Row r applies to raster line Y+r.
- R5: Within a row word, bit 31 covers column X, and bit 31-c covers column X+c.
- R6: Where the mask bit is 0 the input pixel passes. Where it is 1, the output is overlay colour 3 if the colour bit is 1, and overlay colour 2 if it is 0.
- R7: Pixels on lines outside Y..Y+31 or columns outside X..X+31 pass unchanged. Comparisons are unsigned 16-bit, and the window does not wrap past 0xFFFF to zero.
- R8: Pixels with column at or beyond the display width, or line at or beyond the display height, pass unchanged. When X is at or beyond the width, no cursor is drawn.
- R9: Reset sets X and Y to 0xF000, clears both planes and the miscellaneous register, and drives the output pixel to zero.
- R10: The output pixel reflects the inputs of the previous clock cycle, one pixel per cycle without gaps.
- R11: Writes to unmapped offsets change neither the cursor image, the position nor the miscellaneous register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| disp_width | input | 16 | Active display width in pixels |
| disp_height | input | 16 | Active display height in lines |
| pix_x | input | 16 | Current raster column |
| pix_y | input | 16 | Current raster line |
| pix_in | input | 24 | Underlying pixel colour |
| ovl_col2 | input | 24 | Overlay colour for mask 1, colour bit 0 |
| ovl_col3 | input | 24 | Overlay colour for mask 1, colour bit 1 |
| pix_out | output | 24 | Overlaid pixel, one cycle later |

## Verification
The hardest cases are the unsigned window limits. A cursor placed near 0xFFF0 must cover the top of the coordinate space, and lines and columns just above zero must not wrap into it. Clipping at the display width must also hold for a cursor that is only partly visible. The bench reaches these cases by moving the position register and the width and height inputs between directed scans. It sets the width to cut through a fully masked row, and then moves X exactly onto the width. The cursor is then parked at 0xFFF0 with the display enlarged to 0xFFFF, and pixels are probed on both sides of the wrap point.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 12;
    localparam int COORD_W  = 16;
    localparam int PIX_W    = 24;
    localparam int CUR_DIM  = DATA_W;
    localparam int ROW_W    = $clog2(CUR_DIM);
    localparam int PLANE_SH = $clog2(CUR_DIM * 4);
    localparam int N_PLANES = 2;

    localparam logic [ADDR_W-1:0]  OFS_POS  = 12'h8FC;
    localparam logic [ADDR_W-1:0]  OFS_MISC = 12'h818;
    localparam logic [ADDR_W-1:0]  OFS_MASK = 12'h900;
    localparam logic [ADDR_W-1:0]  OFS_BITS = 12'h980;
    localparam logic [DATA_W-1:0]  MISC_FORCE = 32'h0200_0000;
    localparam logic [COORD_W-1:0] POS_RESET  = 16'hF000;
    localparam logic [COORD_W:0]   CUR_SPAN   = (COORD_W + 1)'(CUR_DIM);

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_POS,
        SEL_MASK,
        SEL_BITS,
        SEL_MISC
    } reg_sel_e;

    typedef enum logic [1:0] {
        PICK_PIXEL,
        PICK_COL2,
        PICK_COL3
    } pick_e;

    // x occupies the upper half of the packed word, y the lower half
    typedef struct packed {
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
    } cur_pos_t;

    typedef struct packed {
        logic             hit;
        logic [ROW_W-1:0] row;
        logic [ROW_W-1:0] col;
    } hit_info_t;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        s = SEL_NONE;
        if (a == OFS_POS)
            s = SEL_POS;
        else if (a == OFS_MISC)
            s = SEL_MISC;
        else if (a[ADDR_W-1:PLANE_SH] == OFS_MASK[ADDR_W-1:PLANE_SH])
            s = SEL_MASK;
        else if (a[ADDR_W-1:PLANE_SH] == OFS_BITS[ADDR_W-1:PLANE_SH])
            s = SEL_BITS;
        return s;
    endfunction

    // true when v lies in [lo, lo+CUR_DIM) without wrapping
    function automatic logic in_span(input logic [COORD_W-1:0] lo,
                                     input logic [COORD_W-1:0] v);
        logic [COORD_W:0] d;
        d = {1'b0, v} - {1'b0, lo};
        return (v >= lo) && (d < CUR_SPAN);
    endfunction

endpackage

// File: rtl/cursor_plane.sv
module cursor_plane
    import cursor_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] rows_q [CUR_DIM];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < CUR_DIM; r++)
                rows_q[r] <= '0;
        end else if (wr_en) begin
            rows_q[wr_row] <= wr_data;
        end
    end

    assign rd_word = rows_q[rd_row];

endmodule

// File: rtl/cursor_regs.sv
module cursor_regs
    import cursor_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [ROW_W-1:0]  row_sel,
    output cur_pos_t          pos,
    output logic [DATA_W-1:0] mask_row,
    output logic [DATA_W-1:0] bits_row
);

    reg_sel_e                          sel;
    logic [ROW_W-1:0]                  wr_row;
    logic [N_PLANES-1:0]               plane_we;
    logic [N_PLANES-1:0][DATA_W-1:0]   plane_word;
    cur_pos_t                          pos_q;
    logic [DATA_W-1:0]                 misc_q;

    assign sel    = decode_offset(reg_addr);
    assign wr_row = reg_addr[PLANE_SH-1:2];

    assign plane_we[0] = reg_we && (sel == SEL_MASK);
    assign plane_we[1] = reg_we && (sel == SEL_BITS);

    for (genvar p = 0; p < N_PLANES; p++) begin : g_plane
        cursor_plane u_plane (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (plane_we[p]),
            .wr_row  (wr_row),
            .wr_data (reg_wdata),
            .rd_row  (row_sel),
            .rd_word (plane_word[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '{x: POS_RESET, y: POS_RESET};
            misc_q <= '0;
        end else if (reg_we) begin
            if (sel == SEL_POS)
                pos_q <= cur_pos_t'(reg_wdata);
            if (sel == SEL_MISC)
                misc_q <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (sel == SEL_MISC)
            reg_rdata = misc_q | MISC_FORCE;
    end

    assign pos      = pos_q;
    assign mask_row = plane_word[0];
    assign bits_row = plane_word[1];

endmodule

// File: rtl/cursor_hit.sv
module cursor_hit
    import cursor_pkg::*;
(
    input  cur_pos_t           pos,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [COORD_W-1:0] disp_width,
    input  logic [COORD_W-1:0] disp_height,
    output hit_info_t          info
);

    logic x_in, y_in, visible;

    assign x_in    = in_span(pos.x, pix_x);
    assign y_in    = in_span(pos.y, pix_y);
    assign visible = (pix_x < disp_width) && (pix_y < disp_height)
                   && (pos.x < disp_width);

    assign info.hit = x_in && y_in && visible;
    assign info.row = ROW_W'(pix_y - pos.y);
    assign info.col = ROW_W'(pix_x - pos.x);

endmodule

// File: rtl/cursor_mix.sv
module cursor_mix
    import cursor_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [ROW_W-1:0]  col,
    input  logic [DATA_W-1:0] mask_row,
    input  logic [DATA_W-1:0] bits_row,
    input  logic [PIX_W-1:0]  pix_in,
    input  logic [PIX_W-1:0]  ovl_col2,
    input  logic [PIX_W-1:0]  ovl_col3,
    output logic [PIX_W-1:0]  pix_out
);

    logic [ROW_W-1:0] bidx;
    pick_e            pick;

    // leftmost column is the most significant bit
    assign bidx = ROW_W'(CUR_DIM - 1) - col;

    always_comb begin
        pick = PICK_PIXEL;
        if (hit && mask_row[bidx])
            pick = bits_row[bidx] ? PICK_COL3 : PICK_COL2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_out <= '0;
        end else begin
            unique case (pick)
                PICK_COL2: pix_out <= ovl_col2;
                PICK_COL3: pix_out <= ovl_col3;
                default:   pix_out <= pix_in;
            endcase
        end
    end

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [COORD_W-1:0] disp_width,
    input  logic [COORD_W-1:0] disp_height,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [PIX_W-1:0]   pix_in,
    input  logic [PIX_W-1:0]   ovl_col2,
    input  logic [PIX_W-1:0]   ovl_col3,
    output logic [PIX_W-1:0]   pix_out
);

    cur_pos_t          cur_pos;
    hit_info_t         hit_info;
    logic [DATA_W-1:0] mask_row;
    logic [DATA_W-1:0] bits_row;

    cursor_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .row_sel   (hit_info.row),
        .pos       (cur_pos),
        .mask_row  (mask_row),
        .bits_row  (bits_row)
    );

    cursor_hit u_hit (
        .pos         (cur_pos),
        .pix_x       (pix_x),
        .pix_y       (pix_y),
        .disp_width  (disp_width),
        .disp_height (disp_height),
        .info        (hit_info)
    );

    cursor_mix u_mix (
        .clk      (clk),
        .rst      (rst),
        .hit      (hit_info.hit),
        .col      (hit_info.col),
        .mask_row (mask_row),
        .bits_row (bits_row),
        .pix_in   (pix_in),
        .ovl_col2 (ovl_col2),
        .ovl_col3 (ovl_col3),
        .pix_out  (pix_out)
    );

endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk
    import cursor_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic [COORD_W-1:0] disp_width,
    input logic [COORD_W-1:0] pix_x,
    input logic [COORD_W-1:0] pix_y,
    input logic [PIX_W-1:0]   pix_in,
    input logic [PIX_W-1:0]   ovl_col2,
    input logic [PIX_W-1:0]   ovl_col3,
    input logic [PIX_W-1:0]   pix_out,
    input cur_pos_t           pos
);

    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= 1'b1;
    end

    a_r2_misc_forced_bit: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_MISC) |-> ((reg_rdata & MISC_FORCE) == MISC_FORCE));

    a_r3_other_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr != OFS_MISC) |-> (reg_rdata == '0));

    a_r7_above_window_pass: assert property (@(posedge clk) disable iff (rst)
        (seen_q && $past(pix_y < pos.y)) |-> (pix_out == $past(pix_in)));

    a_r8_clip_column_pass: assert property (@(posedge clk) disable iff (rst)
        (seen_q && $past(pix_x >= disp_width)) |-> (pix_out == $past(pix_in)));

    a_r9_reset_offscreen: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pos.x == POS_RESET && pos.y == POS_RESET));

    a_r10_output_source: assert property (@(posedge clk) disable iff (rst)
        seen_q |-> (pix_out == $past(pix_in) || pix_out == $past(ovl_col2)
                    || pix_out == $past(ovl_col3)));

endmodule

bind cursor_overlay cursor_overlay_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .disp_width (disp_width),
    .pix_x      (pix_x),
    .pix_y      (pix_y),
    .pix_in     (pix_in),
    .ovl_col2   (ovl_col2),
    .ovl_col3   (ovl_col3),
    .pix_out    (pix_out),
    .pos        (cur_pos)
);

// File: tb/cursor_overlay_tb.sv
`timescale 1ns/1ps
module cursor_overlay_tb;

    localparam logic [23:0] C2 = 24'h112233;
    localparam logic [23:0] C3 = 24'hAABBCC;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [15:0] disp_width, disp_height;
    logic [15:0] pix_x, pix_y;
    logic [23:0] pix_in;
    logic [23:0] ovl_col2, ovl_col3;
    logic [23:0] pix_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // requirement-level model state
    logic [31:0] m_mask [32];
    logic [31:0] m_bits [32];
    logic [31:0] m_misc;
    int          m_x, m_y;

    always #4 clk = ~clk;

    cursor_overlay u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .disp_width(disp_width), .disp_height(disp_height),
        .pix_x(pix_x), .pix_y(pix_y), .pix_in(pix_in),
        .ovl_col2(ovl_col2), .ovl_col3(ovl_col3), .pix_out(pix_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] mk_pix(input int x, input int y);
        return {x[7:0], y[7:0], 8'h5A};
    endfunction

    function automatic logic [23:0] expect_pix(input int x, input int y);
        int row, col;
        if (x >= int'(disp_width) || y >= int'(disp_height) || m_x >= int'(disp_width))
            return mk_pix(x, y);
        if (y < m_y || y >= m_y + 32 || x < m_x || x >= m_x + 32)
            return mk_pix(x, y);
        row = y - m_y;
        col = x - m_x;
        if (!m_mask[row][31-col]) return mk_pix(x, y);
        return m_bits[row][31-col] ? C3 : C2;
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a == 12'h8FC) begin
            m_x = int'(d[31:16]); m_y = int'(d[15:0]);
        end else if (a == 12'h818) begin
            m_misc = d;
        end else if (a >= 12'h900 && a < 12'h980) begin
            m_mask[(a - 12'h900) >> 2] = d;
        end else if (a >= 12'h980 && a < 12'hA00) begin
            m_bits[(a - 12'h980) >> 2] = d;
        end
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic px(input string req, input int x, input int y);
        @(negedge clk);
        pix_x = 16'(x); pix_y = 16'(y); pix_in = mk_pix(x, y);
        @(negedge clk);
        chk(req, {8'h0, pix_out}, {8'h0, expect_pix(x, y)});
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R9 output zero in reset", {8'h0, pix_out}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        rd_chk("R2 R9 misc after reset", 12'h818, 32'h0200_0000);
        px("R9 offscreen cursor passes pixel", 0, 0);
        px("R9 planes cleared at reset position", 16'hF000, 16'hF000);
    endtask

    task automatic t_regs;
        wr(12'h818, 32'h00A5_0001);
        rd_chk("R2 misc readback", 12'h818, 32'h02A5_0001);
        wr(12'h8FC, {16'd100, 16'd50});
        rd_chk("R3 position reads zero", 12'h8FC, 32'h0);
        rd_chk("R3 mask plane reads zero", 12'h900, 32'h0);
        rd_chk("R3 colour plane reads zero", 12'h9FC, 32'h0);
    endtask

    task automatic t_shape;
        for (int r = 0; r < 32; r++) begin
            wr(12'h900 + 12'(4 * r), 32'h8000_0001 | (32'h1 << r) | ((r % 2 == 1) ? 32'h00FF_0000 : 32'h0));
            wr(12'h980 + 12'(4 * r), 32'hAAAA_AAAA ^ (32'h1 << (31 - r)));
        end
        wr(12'h8FC, {16'd100, 16'd50});
        px("R6 mask1 colour0 gives colour 2 at origin", 100, 50);
        chk("R1 R5 origin value", {8'h0, pix_out}, {8'h0, C2});
        px("R5 rightmost column bit 0", 131, 50);
        px("R7 column after window", 132, 50);
        px("R7 column before window", 99, 50);
        px("R7 line before window", 100, 49);
        px("R4 last row", 131, 81);
        px("R7 line after window", 100, 82);
        for (int yi = 0; yi < 32; yi += 3)
            for (int xi = 0; xi < 32; xi += 5)
                px("R4 R5 R6 shape scan", 100 + xi, 50 + yi);
    endtask

    task automatic t_clip;
        wr(12'h900, 32'hFFFF_FFFF);
        wr(12'h980, 32'h0000_0000);
        disp_width = 16'd110;
        px("R8 last visible column drawn", 109, 50);
        chk("R8 visible column colour 2", {8'h0, pix_out}, {8'h0, C2});
        px("R8 column at width clipped", 110, 50);
        px("R8 column beyond width clipped", 115, 50);
        wr(12'h8FC, {16'd110, 16'd50});
        px("R8 X at width hides cursor", 110, 50);
        wr(12'h8FC, {16'd100, 16'd50});
        disp_height = 16'd50;
        px("R8 line at height clipped", 100, 50);
        disp_width = 16'd640;
        disp_height = 16'd480;
    endtask

    task automatic t_wrap;
        disp_width = 16'hFFFF;
        disp_height = 16'hFFFF;
        wr(12'h8FC, {16'hFFF0, 16'hFFF0});
        px("R7 window at top of space", 16'hFFF0, 16'hFFF0);
        chk("R7 top window colour", {8'h0, pix_out}, {8'h0, C2});
        px("R7 shape near top", 16'hFFFE, 16'hFFFE);
        px("R7 no wrap of lines", 16'hFFF5, 16'h0005);
        px("R7 no wrap of columns", 16'h0003, 16'hFFF0);
        px("R7 origin not covered", 0, 0);
        disp_width = 16'd640;
        disp_height = 16'd480;
        wr(12'h8FC, {16'd100, 16'd50});
    endtask

    task automatic t_stream;
        int px_x, px_y;
        @(negedge clk);
        pix_x = 16'd95; pix_y = 16'd51; pix_in = mk_pix(95, 51);
        for (int i = 1; i <= 40; i++) begin
            px_x = 95 + i - 1; px_y = 51;
            @(negedge clk);
            chk("R10 one cycle latency stream", {8'h0, pix_out}, {8'h0, expect_pix(px_x, px_y)});
            pix_x = 16'(95 + i); pix_in = mk_pix(95 + i, 51);
        end
    endtask

    task automatic t_ignored;
        wr(12'h8F8, 32'h0000_0000);
        wr(12'h81C, 32'hFFFF_FFFF);
        wr(12'hA00, 32'h0000_0000);
        wr(12'h8FD, 32'h0000_0000);
        rd_chk("R11 misc unchanged", 12'h818, 32'h02A5_0001);
        px("R11 position and image unchanged", 100, 50);
        chk("R11 cursor still drawn", {8'h0, pix_out}, {8'h0, C2});
        px("R11 neighbour pixel", 101, 51);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        disp_width = 16'd640; disp_height = 16'd480;
        pix_x = '0; pix_y = '0; pix_in = '0;
        ovl_col2 = C2; ovl_col3 = C3;
        m_misc = '0; m_x = 16'hF000; m_y = 16'hF000;
        for (int r = 0; r < 32; r++) begin
            m_mask[r] = '0; m_bits[r] = '0;
        end
        repeat (3) @(negedge clk);
        t_reset;
        t_regs;
        t_shape;
        t_clip;
        t_wrap;
        t_stream;
        t_ignored;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule